// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one down-counting timer channel with a selectable operating mode. It counts pulses of a count-clock enable (`cnt_en`) sampled on the system clock. A gate input starts, restarts or suspends counting, depending on the mode. The `out_pin` output produces the waveform for the selected mode. A separate register front end supplies the mode number, the binary/BCD flag and the initial count through single-cycle strobes. That front end also reads `count_out`, which it can latch, and `out_pin`, which it reports as status. Bus decoding, byte sequencing and interrupt delivery belong to that front end and are not part of this block.

The six modes are:

- Mode 0: terminal-count flag.
- Mode 1: gate-retriggered one-shot.
- Mode 2: periodic rate pulse.
- Mode 3: square wave.
- Mode 4: software-started strobe.
- Mode 5: gate-started strobe.

An initial count of zero stands for the largest count: 2^CW in binary, 10^(CW/4) in BCD. This follows from the counter wrapping through zero.

There is no handshake and no back-pressure. Every input is a level or a one-cycle strobe, and a strobe takes effect in the cycle it is seen. When strobes coincide, `mode_wr` takes priority over `load_wr`, and `load_wr` takes priority over `cnt_en`.

Top module: `ivt_channel`

## Requirements
- R1: After reset, `out_pin` is 1 and `count_out` is 0.
- R2: The counter changes only on cycles where `cnt_en` is 1. A written initial count appears on `count_out` at the first `cnt_en` cycle after the write (or after the gate trigger in modes 1 and 5). Decrementing starts on the following `cnt_en` cycle.
- R3: An initial count of 0 gives a terminal count after 2^CW count clocks in binary and 10^(CW/4) in BCD.
- R4: In modes 0, 1, 4 and 5, the counter passes through zero and continues from all-ones (binary) or from all-nines (BCD).
- R5: With `bcd_in`=1, each 4-bit digit counts down from 0 to 9 and takes a borrow from the digit above it.
- R6: In mode 0:
  - `out_pin` goes to 0 on a count write.
  - `out_pin` rises on the count clock where the counter reaches 0.
  - `out_pin` then stays at 1 until the next mode or count write.
- R7: In mode 1:
  - A rising edge on `gate` after a count write loads the count on the next count clock and drives `out_pin` to 0.
  - `out_pin` returns to 1 when the counter reaches 0.
  - A later rising edge restarts the count.
- R8: In mode 2, the counter reloads the initial count where it would reach 0. `out_pin` is 0 for exactly that one count period, first after N count clocks and then every N count clocks.
- R9: In mode 3, with period N, `out_pin` is 1 for the first (N+1)/2 count periods and 0 for the remaining N/2. The counter then reloads.
- R10: In mode 4, after a count write, `out_pin` is 0 for exactly one count period when the counter first reaches 0.
- R11: In mode 5, the same single low strobe as in mode 4 follows a rising edge on `gate`, not the count write.
- R12: In modes 0, 2, 3 and 4, `gate`=0 holds the counter. In modes 2 and 3, `gate`=0 also forces `out_pin` to 1 on the next count clock. In modes 2 and 3, a rising edge on `gate` reloads the initial count.
- R13: A mode write stops counting. It sets `out_pin` to 0 for mode 0 and to 1 for every other mode. Mode codes 6 and 7 on `mode_in` select modes 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count-clock enable; each high cycle is one count clock |
| gate | input | 1 | Gate level; its rising edge is the trigger |
| mode_wr | input | 1 | Strobe: latch `mode_in` and `bcd_in` |
| mode_in | input | 3 | Mode number 0..7 (6 and 7 map to 2 and 3) |
| bcd_in | input | 1 | 1 selects BCD counting, 0 selects binary |
| load_wr | input | 1 | Strobe: latch `load_val` as the initial count |
| load_val | input | CW | Initial count (0 means the largest count) |
| count_out | output | CW | Current counter value |
| out_pin | output | 1 | Channel output |

## Verification
The bench builds the channel with CW=8, which gives two BCD digits. At that width the zero-means-maximum load needs only 256 binary or 100 BCD count clocks. This lets the bench follow every step of a full wrap from 0 to the terminal count in both number systems, including the borrow between the two BCD digits. The short counts used in the mode tests (2 to 5) keep the periodic modes within a few cycles per period. This makes the odd and even square-wave splits, and the single-period strobes, easy to check one count clock at a time.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

  typedef enum logic [2:0] {
    MD_TERM   = 3'd0,
    MD_RETRIG = 3'd1,
    MD_RATE   = 3'd2,
    MD_SQUARE = 3'd3,
    MD_SWSTB  = 3'd4,
    MD_HWSTB  = 3'd5
  } ivt_mode_e;

  // Field values 6 and 7 alias the two periodic modes.
  function automatic ivt_mode_e map_mode(input logic [2:0] f);
    case (f)
      3'd6:    return MD_RATE;
      3'd7:    return MD_SQUARE;
      default: return ivt_mode_e'(f);
    endcase
  endfunction

  // Modes whose count restarts on a gate rising edge.
  function automatic logic retrig_mode(input ivt_mode_e m);
    return (m == MD_RETRIG) || (m == MD_RATE) || (m == MD_SQUARE) || (m == MD_HWSTB);
  endfunction

  // Modes that start on a count write and use gate as a count enable.
  function automatic logic level_mode(input ivt_mode_e m);
    return (m == MD_TERM) || (m == MD_RATE) || (m == MD_SQUARE) || (m == MD_SWSTB);
  endfunction

endpackage

// File: rtl/ivt_gate_edge.sv
module ivt_gate_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  output logic rise
);
  logic gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate;
  end

  assign rise = gate & ~gate_q;
endmodule

// File: rtl/ivt_decr.sv
module ivt_decr #(
  parameter int CW = 16
) (
  input  logic [CW-1:0] val,
  input  logic          bcd,
  output logic [CW-1:0] dec
);
  localparam int DIG = CW / 4;

  logic [DIG-1:0] bor;
  logic [CW-1:0]  bcd_dec;
  logic [CW-1:0]  bin_dec;

  assign bor[0]  = 1'b1;
  assign bin_dec = val - {{(CW-1){1'b0}}, 1'b1};

  for (genvar g = 0; g < DIG; g++) begin : g_dig
    logic [3:0] d;
    assign d = val[4*g +: 4];
    assign bcd_dec[4*g +: 4] = !bor[g]       ? d :
                               (d == 4'd0)   ? 4'd9 : d - 4'd1;
    if (g < DIG - 1) begin : g_bor
      assign bor[g+1] = bor[g] & (d == 4'd0);
    end
  end

  assign dec = bcd ? bcd_dec : bin_dec;
endmodule

// File: rtl/ivt_half.sv
module ivt_half #(
  parameter int CW = 16
) (
  input  logic [CW-1:0] init,
  input  logic          bcd,
  output logic [CW-1:0] half
);
  localparam int DIG = CW / 4;
  localparam logic [CW-1:0] BIN_MAX_HALF = {1'b1, {(CW-1){1'b0}}};
  localparam logic [CW-1:0] BCD_MAX_HALF = {4'd5, {(CW-4){1'b0}}};

  logic [DIG-1:0] cin;
  logic [CW-1:0]  bcd_half;

  assign cin[DIG-1] = 1'b0;

  // Halve digit by digit from the top: (10*c + d) / 2 = 5*c + d/2.
  for (genvar g = DIG - 1; g >= 0; g--) begin : g_dig
    logic [3:0] d;
    assign d = init[4*g +: 4];
    assign bcd_half[4*g +: 4] = (cin[g] ? 4'd5 : 4'd0) + {1'b0, d[3:1]};
    if (g > 0) begin : g_c
      assign cin[g-1] = d[0];
    end
  end

  always_comb begin
    if (init == '0)  half = bcd ? BCD_MAX_HALF : BIN_MAX_HALF;
    else if (bcd)    half = bcd_half;
    else             half = {1'b0, init[CW-1:1]};
  end
endmodule

// File: rtl/ivt_channel.sv
module ivt_channel
  import ivt_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          gate,
  input  logic          mode_wr,
  input  logic [2:0]    mode_in,
  input  logic          bcd_in,
  input  logic          load_wr,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] count_out,
  output logic          out_pin
);
  ivt_mode_e     mode_q, mode_n, mode_new;
  logic          bcd_q, bcd_n;
  logic [CW-1:0] init_q, init_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          out_q, out_n;
  logic          run_q, run_n;
  logic          pend_q, pend_n;
  logic          trig_q, trig_n;
  logic          fired_q, fired_n;
  logic          have_q, have_n;

  logic          gate_rise;
  logic [CW-1:0] dec_val;
  logic [CW-1:0] half_val;
  logic          dec_zero;
  logic          start;
  logic          lvl_ok;
  logic [CW-1:0] per_nxt;

  ivt_gate_edge u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .gate (gate),
    .rise (gate_rise)
  );

  ivt_decr #(.CW(CW)) u_dec (
    .val(cnt_q),
    .bcd(bcd_q),
    .dec(dec_val)
  );

  ivt_half #(.CW(CW)) u_half (
    .init(init_q),
    .bcd (bcd_q),
    .half(half_val)
  );

  assign mode_new = map_mode(mode_in);
  assign dec_zero = (dec_val == '0);
  assign start    = pend_q | (trig_q & retrig_mode(mode_q));
  assign lvl_ok   = !level_mode(mode_q) | gate;
  assign per_nxt  = dec_zero ? init_q : dec_val;

  always_comb begin
    mode_n  = mode_q;
    bcd_n   = bcd_q;
    init_n  = init_q;
    cnt_n   = cnt_q;
    out_n   = out_q;
    run_n   = run_q;
    pend_n  = pend_q;
    trig_n  = trig_q;
    fired_n = fired_q;
    have_n  = have_q;
    if (mode_wr) begin
      mode_n  = mode_new;
      bcd_n   = bcd_in;
      run_n   = 1'b0;
      pend_n  = 1'b0;
      trig_n  = 1'b0;
      have_n  = 1'b0;
      fired_n = 1'b0;
      out_n   = (mode_new != MD_TERM);
    end else begin
      if (load_wr) begin
        init_n = load_val;
        have_n = 1'b1;
        if (level_mode(mode_q)) pend_n = 1'b1;
        if (mode_q == MD_TERM)  out_n  = 1'b0;
      end else if (cnt_en) begin
        if (start) begin
          cnt_n   = init_q;
          pend_n  = 1'b0;
          trig_n  = 1'b0;
          run_n   = 1'b1;
          fired_n = 1'b0;
          out_n   = !((mode_q == MD_TERM) || (mode_q == MD_RETRIG));
        end else begin
          if (((mode_q == MD_SWSTB) || (mode_q == MD_HWSTB)) && !out_q) out_n = 1'b1;
          if (((mode_q == MD_RATE) || (mode_q == MD_SQUARE)) && !gate) out_n = 1'b1;
          if (run_q && lvl_ok) begin
            case (mode_q)
              MD_TERM, MD_RETRIG: begin
                cnt_n = dec_val;
                if (dec_zero) out_n = 1'b1;
              end
              MD_RATE: begin
                cnt_n = per_nxt;
                out_n = !dec_zero;
              end
              MD_SQUARE: begin
                cnt_n = per_nxt;
                out_n = (per_nxt == '0) || (per_nxt > half_val);
              end
              default: begin
                cnt_n = dec_val;
                if (dec_zero && !fired_q && out_q) begin
                  out_n   = 1'b0;
                  fired_n = 1'b1;
                end
              end
            endcase
          end
        end
      end
      if (gate_rise && have_q && retrig_mode(mode_q)) trig_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MD_TERM;
      bcd_q   <= 1'b0;
      init_q  <= '0;
      cnt_q   <= '0;
      out_q   <= 1'b1;
      run_q   <= 1'b0;
      pend_q  <= 1'b0;
      trig_q  <= 1'b0;
      fired_q <= 1'b0;
      have_q  <= 1'b0;
    end else begin
      mode_q  <= mode_n;
      bcd_q   <= bcd_n;
      init_q  <= init_n;
      cnt_q   <= cnt_n;
      out_q   <= out_n;
      run_q   <= run_n;
      pend_q  <= pend_n;
      trig_q  <= trig_n;
      fired_q <= fired_n;
      have_q  <= have_n;
    end
  end

  assign count_out = cnt_q;
  assign out_pin   = out_q;
endmodule

// File: rtl/ivt_channel_chk.sv
module ivt_channel_chk
  import ivt_pkg::*;
#(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cnt_en,
  input logic          mode_wr,
  input logic [2:0]    mode_in,
  input logic          load_wr,
  input logic [CW-1:0] count_out,
  input logic          out_pin,
  input ivt_mode_e     mode_q
);

  a_r2_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(count_out));

  a_r2_out_only_on_events: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !mode_wr && !load_wr) |=> $stable(out_pin));

  a_r13_mode0_write_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && mode_in == 3'd0) |=> !out_pin);

  a_r13_other_write_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && mode_in != 3'd0) |=> out_pin);

  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_TERM && out_pin && !mode_wr && !load_wr) |=> out_pin);

  a_r10_strobe_one_period: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MD_SWSTB || mode_q == MD_HWSTB) && !out_pin && cnt_en && !mode_wr && !load_wr)
      |=> out_pin);

endmodule

bind ivt_channel ivt_channel_chk #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnt_en   (cnt_en),
  .mode_wr  (mode_wr),
  .mode_in  (mode_in),
  .load_wr  (load_wr),
  .count_out(count_out),
  .out_pin  (out_pin),
  .mode_q   (mode_q)
);

// File: tb/sim_ivt_channel.sv
module sim_ivt_channel;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cnt_en = 1'b0;
  logic          gate = 1'b1;
  logic          mode_wr = 1'b0;
  logic [2:0]    mode_in = 3'd0;
  logic          bcd_in = 1'b0;
  logic          load_wr = 1'b0;
  logic [CW-1:0] load_val = '0;
  logic [CW-1:0] count_out;
  logic          out_pin;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [CW-1:0] c;
    logic          o;
    logic          use_c;
    string         tag;
  } exp_t;

  exp_t sb[$];

  always #10 clk = ~clk;

  ivt_channel #(.CW(CW)) u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_en   (cnt_en),
    .gate     (gate),
    .mode_wr  (mode_wr),
    .mode_in  (mode_in),
    .bcd_in   (bcd_in),
    .load_wr  (load_wr),
    .load_val (load_val),
    .count_out(count_out),
    .out_pin  (out_pin)
  );

  // Monitor: compares outputs 5 ns after each edge with items queued before it.
  always @(posedge clk) begin
    #5;
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if ((out_pin !== e.o) || (e.use_c && (count_out !== e.c))) begin
        fails++;
        $display("FAIL %s: count=%h out=%b expected count=%h out=%b",
                 e.tag, count_out, out_pin, e.c, e.o);
      end
    end
  end

  function automatic logic [7:0] to_bcd(input int v);
    return {4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  task automatic step(input logic en, input logic mw, input logic lw, input logic chk,
                      input logic uc, input logic [CW-1:0] ec, input logic eo, input string tag);
    @(negedge clk);
    cnt_en  = en;
    mode_wr = mw;
    load_wr = lw;
    if (chk) sb.push_back('{ec, eo, uc, tag});
  endtask

  task automatic prog(input logic [2:0] m, input logic b, input logic eo, input string tag);
    mode_in = m;
    bcd_in  = b;
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, '0, eo, tag);
  endtask

  task automatic load(input logic [CW-1:0] v, input logic eo, input string tag);
    load_val = v;
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, '0, eo, tag);
  endtask

  task automatic tk(input logic [CW-1:0] ec, input logic eo, input string tag);
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, ec, eo, tag);
  endtask

  task automatic idle(input logic [CW-1:0] ec, input logic eo, input string tag);
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, ec, eo, tag);
  endtask

  task automatic set_gate(input logic g);
    @(negedge clk);
    gate    = g;
    cnt_en  = 1'b0;
    mode_wr = 1'b0;
    load_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(8'h00, 1'b1, "R1 reset state");

    // Mode 0, N=5
    prog(3'd0, 1'b0, 1'b0, "R13 mode0 write low");
    load(8'd5, 1'b0, "R6 write keeps low");
    idle(8'h00, 1'b0, "R2 no count clock");
    tk(8'd5, 1'b0, "R2 load on first clock");
    for (int k = 1; k <= 4; k++) tk(CW'(5 - k), 1'b0, "R6 counting");
    tk(8'd0, 1'b1, "R6 terminal");
    tk(8'hFF, 1'b1, "R4 binary wrap");
    idle(8'hFF, 1'b1, "R6 sticky");

    // Mode 0 gate suspend
    load(8'd3, 1'b0, "R6 rewrite low");
    tk(8'd3, 1'b0, "R6 reload");
    set_gate(1'b0);
    tk(8'd3, 1'b0, "R12 gate low holds");
    tk(8'd3, 1'b0, "R12 gate low holds");
    set_gate(1'b1);
    tk(8'd2, 1'b0, "R12 resume");
    tk(8'd1, 1'b0, "R12 resume");
    tk(8'd0, 1'b1, "R12 terminal");

    // Mode 1, N=3
    prog(3'd1, 1'b0, 1'b1, "R13 mode1 write high");
    load(8'd3, 1'b1, "R7 write no effect");
    tk(8'd0, 1'b1, "R7 waits for trigger");
    set_gate(1'b0);
    set_gate(1'b1);
    tk(8'd3, 1'b0, "R7 triggered");
    tk(8'd2, 1'b0, "R7 low");
    tk(8'd1, 1'b0, "R7 low");
    tk(8'd0, 1'b1, "R7 terminal high");
    tk(8'hFF, 1'b1, "R4 mode1 wrap");
    set_gate(1'b0);
    set_gate(1'b1);
    tk(8'd3, 1'b0, "R7 retrigger");
    prog(3'd0, 1'b0, 1'b0, "R13 mode write");
    tk(8'd3, 1'b0, "R13 counting halted");

    // Mode 2, N=3
    prog(3'd2, 1'b0, 1'b1, "R13 mode2 write high");
    load(8'd3, 1'b1, "R8 write");
    tk(8'd3, 1'b1, "R8 load");
    tk(8'd2, 1'b1, "R8 count");
    tk(8'd1, 1'b1, "R8 count");
    tk(8'd3, 1'b0, "R8 pulse and reload");
    tk(8'd2, 1'b1, "R8 pulse one period");
    tk(8'd1, 1'b1, "R8 count");
    tk(8'd3, 1'b0, "R8 second pulse");
    set_gate(1'b0);
    tk(8'd3, 1'b1, "R12 gate low forces high");
    tk(8'd3, 1'b1, "R12 gate low holds");
    set_gate(1'b1);
    tk(8'd3, 1'b1, "R12 gate rise reloads");
    tk(8'd2, 1'b1, "R12 count after reload");

    // Mode code 6 aliases mode 2, N=2
    prog(3'd6, 1'b0, 1'b1, "R13 code6 write high");
    load(8'd2, 1'b1, "R13 code6 write");
    tk(8'd2, 1'b1, "R13 code6 load");
    tk(8'd1, 1'b1, "R13 code6 count");
    tk(8'd2, 1'b0, "R13 code6 acts as rate");

    // Mode 3, N=5
    prog(3'd3, 1'b0, 1'b1, "R13 mode3 write high");
    load(8'd5, 1'b1, "R9 write");
    tk(8'd5, 1'b1, "R9 odd high 1");
    tk(8'd4, 1'b1, "R9 odd high 2");
    tk(8'd3, 1'b1, "R9 odd high 3");
    tk(8'd2, 1'b0, "R9 odd low 1");
    tk(8'd1, 1'b0, "R9 odd low 2");
    tk(8'd5, 1'b1, "R9 odd reload high");
    tk(8'd4, 1'b1, "R9 odd high");

    // Mode code 7 aliases mode 3, N=4
    prog(3'd7, 1'b0, 1'b1, "R13 code7 write high");
    load(8'd4, 1'b1, "R9 even write");
    tk(8'd4, 1'b1, "R9 even high 1");
    tk(8'd3, 1'b1, "R9 even high 2");
    tk(8'd2, 1'b0, "R9 even low 1");
    tk(8'd1, 1'b0, "R9 even low 2");
    tk(8'd4, 1'b1, "R13 code7 acts as square");

    // Mode 4, N=2
    prog(3'd4, 1'b0, 1'b1, "R13 mode4 write high");
    load(8'd2, 1'b1, "R10 write");
    tk(8'd2, 1'b1, "R10 load");
    tk(8'd1, 1'b1, "R10 count");
    tk(8'd0, 1'b0, "R10 strobe");
    tk(8'hFF, 1'b1, "R10 strobe one period, R4 wrap");
    tk(8'hFE, 1'b1, "R10 no second strobe");

    // Mode 5, N=2
    prog(3'd5, 1'b0, 1'b1, "R13 mode5 write high");
    load(8'd2, 1'b1, "R11 write");
    tk(8'hFE, 1'b1, "R11 waits for trigger");
    set_gate(1'b0);
    set_gate(1'b1);
    tk(8'd2, 1'b1, "R11 triggered load");
    tk(8'd1, 1'b1, "R11 count");
    tk(8'd0, 1'b0, "R11 strobe");
    tk(8'hFF, 1'b1, "R11 strobe one period");

    // Zero means maximum, binary
    prog(3'd0, 1'b0, 1'b0, "R13 mode0 write low");
    load(8'd0, 1'b0, "R3 write zero");
    tk(8'd0, 1'b0, "R3 load zero");
    for (int k = 1; k <= 255; k++) tk(CW'(256 - k), 1'b0, "R3 binary full count");
    tk(8'd0, 1'b1, "R3 binary terminal after 256");

    // Zero means maximum, BCD
    prog(3'd0, 1'b1, 1'b0, "R13 bcd mode0 write");
    load(8'h00, 1'b0, "R3 bcd write zero");
    tk(8'h00, 1'b0, "R3 bcd load zero");
    for (int k = 1; k <= 99; k++) tk(to_bcd(100 - k), 1'b0, "R5 bcd digit borrow");
    tk(8'h00, 1'b1, "R3 bcd terminal after 100");
    tk(8'h99, 1'b1, "R4 bcd wrap to 99");

    // BCD mode 2, N=10
    prog(3'd2, 1'b1, 1'b1, "R13 bcd mode2 write");
    load(8'h10, 1'b1, "R8 bcd write");
    tk(8'h10, 1'b1, "R8 bcd load");
    for (int k = 1; k <= 9; k++) tk(to_bcd(10 - k), 1'b1, "R5 bcd rate count");
    tk(8'h10, 1'b0, "R8 bcd pulse and reload");
    tk(8'h09, 1'b1, "R8 bcd pulse one period");

    set_gate(1'b1);
    @(posedge clk);
    #6;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule